// File: doc/BRIEF.md
# Trigger Latency Buffer

This block holds the binary hit pattern of 128 channels for every bunch crossing in a circular memory of 256 slices. A write pointer steps once per clock, so each slice survives for 256 crossings before it is overwritten. When a level-1 trigger strobe arrives, the block looks back by a programmable number of crossings and copies that slice into a 32-entry event buffer. Each stored event also records the ring address it came from.

Every event carries two error flags. The latency flag marks a slice that cannot be trusted: the look-back is zero, it reaches further back than the ring has been filled since reset, or the address tag stored with the slice does not match. The overflow flag is sticky. It is raised the first time a trigger is dropped because the event buffer is full, and every event stored after that carries it until the next reset. A downstream serializer drains the buffer with a read request and receives the event one cycle later on registered outputs.

Top module: `l1_latency_buffer`

## Requirements
- R1: After reset the write pointer starts at 0 on the first clock edge and advances by one on every edge, wrapping from 255 to 0. This is visible in the address of captured events.
- R2: A trigger sampled on edge n with look-back L (1..255, and at most n) yields an event whose hits equal the vector sampled on edge n-L.
- R3: The address of an event is (n - L) modulo 256, where n counts edges since reset.
- R4: The latency flag is 1 when L is 0 or L exceeds the number of edges since reset (saturating at 256). Otherwise it is 0. When the flag is 1 the hit content is unspecified.
- R5: The event buffer holds up to 32 events and returns them in trigger order.
- R6: A trigger whose event would be stored while the buffer holds 32 events is dropped, and the sticky overflow flag is set. Every event stored afterwards carries the flag as 1. Reset clears it.
- R7: A read request sampled while the buffer is non-empty makes the valid output high on the next edge, carrying the oldest event. A request on an empty buffer produces no valid output.
- R8: During and right after reset, the valid output, the hits, the address and both flags are 0.
- R9: The look-back is sampled on the trigger edge itself, so consecutive triggers may each use a different value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| hits_i | input | 128 | Binary channel hits for this crossing |
| trig_i | input | 1 | Level-1 trigger strobe |
| latency_i | input | 8 | Look-back in crossings |
| rd_req_i | input | 1 | Read request from serializer |
| ev_valid_o | output | 1 | Event outputs valid this cycle |
| ev_hits_o | output | 128 | Buffered hit vector |
| ev_addr_o | output | 8 | Ring address of the slice |
| ev_lat_err_o | output | 1 | Latency error flag of the event |
| ev_ovf_o | output | 1 | Overflow flag of the event |

## Verification
A trigger sampled on edge n has its slice read from the ring on that same edge. The event is written into the buffer on edge n+1, so a read request may be issued on edge n+2 at the earliest, and the event appears on the outputs one edge after that request. The bench models the buffer occupancy and the sticky overflow at the moment each trigger is issued, and queues the expected event. It keeps trigger bursts and read bursts separated by idle cycles, so the model never has to resolve a push and a pop on the same edge. A monitor samples at the falling edge and pops one expected event for each valid output. An empty read request is checked one falling edge after the request.

// File: rtl/l1lb_pkg.sv
package l1lb_pkg;
  localparam int CH_W = 128;
  localparam int PA_W = 8;

  typedef struct packed {
    logic            lat_err;
    logic            ovf;
    logic [PA_W-1:0] addr;
    logic [CH_W-1:0] hits;
  } l1_event_t;
endpackage

// File: rtl/l1lb_ring.sv
module l1lb_ring #(
  parameter int DW = 136,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // Plain dual-port memory with a registered read: read-before-write on a collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/l1lb_fifo.sv
module l1lb_fifo #(
  parameter int W     = 138,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       dout_valid,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp         <= '0;
      rp         <= '0;
      count      <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= pop_ok;
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok) begin
        dout <= mem[rp];
        rp   <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/l1lb_trig_ctrl.sv
module l1lb_trig_ctrl
  import l1lb_pkg::*;
#(
  parameter int AW = PA_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig_i,
  input  logic [AW-1:0]   latency_i,
  input  logic            buf_full,
  input  logic [CH_W-1:0] ring_hits,
  input  logic [AW-1:0]   ring_tag,
  output logic [AW-1:0]   wr_ptr,
  output logic [AW-1:0]   rd_addr,
  output logic            push,
  output l1_event_t       push_ev,
  output logic            ovf
);
  localparam int DEPTH = 2 ** AW;
  localparam int FW    = $clog2(DEPTH + 1);

  logic [FW-1:0] fill;
  logic          trig_q;
  logic [AW-1:0] exp_q;
  logic          age_ok_q;

  assign rd_addr = wr_ptr - latency_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      fill     <= '0;
      trig_q   <= 1'b0;
      exp_q    <= '0;
      age_ok_q <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      wr_ptr   <= wr_ptr + 1'b1;
      if (fill != FW'(DEPTH)) fill <= fill + 1'b1;
      trig_q   <= trig_i;
      exp_q    <= rd_addr;
      age_ok_q <= (latency_i != '0) && ({1'b0, latency_i} <= fill);
      if (trig_q && buf_full) ovf <= 1'b1;
    end
  end

  assign push = trig_q && !buf_full;

  always_comb begin
    push_ev.hits = ring_hits;
    push_ev.addr = exp_q;
    push_ev.ovf  = ovf;
    if (!age_ok_q) push_ev.lat_err = 1'b1;
    else           push_ev.lat_err = (ring_tag != exp_q);
  end
endmodule

// File: rtl/l1_latency_buffer.sv
module l1_latency_buffer
  import l1lb_pkg::*;
#(
  parameter int BUF_DEPTH = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH_W-1:0] hits_i,
  input  logic            trig_i,
  input  logic [PA_W-1:0] latency_i,
  input  logic            rd_req_i,
  output logic            ev_valid_o,
  output logic [CH_W-1:0] ev_hits_o,
  output logic [PA_W-1:0] ev_addr_o,
  output logic            ev_lat_err_o,
  output logic            ev_ovf_o
);
  localparam int RW = CH_W + PA_W;
  localparam int EW = $bits(l1_event_t);
  localparam int CW = $clog2(BUF_DEPTH + 1);

  logic [PA_W-1:0] wr_ptr, rd_addr;
  logic [RW-1:0]   ring_q;
  logic            push, full, ovf;
  l1_event_t       push_ev, out_ev;
  logic [EW-1:0]   fifo_q;
  logic [CW-1:0]   count;

  l1lb_ring #(.DW(RW), .AW(PA_W)) u_ring (
    .clk   (clk),
    .we    (!rst),
    .waddr (wr_ptr),
    .wdata ({wr_ptr, hits_i}),
    .raddr (rd_addr),
    .rdata (ring_q)
  );

  l1lb_trig_ctrl #(.AW(PA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .trig_i    (trig_i),
    .latency_i (latency_i),
    .buf_full  (full),
    .ring_hits (ring_q[CH_W-1:0]),
    .ring_tag  (ring_q[RW-1:CH_W]),
    .wr_ptr    (wr_ptr),
    .rd_addr   (rd_addr),
    .push      (push),
    .push_ev   (push_ev),
    .ovf       (ovf)
  );

  l1lb_fifo #(.W(EW), .DEPTH(BUF_DEPTH)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .din        (push_ev),
    .pop        (rd_req_i),
    .dout       (fifo_q),
    .dout_valid (ev_valid_o),
    .full       (full),
    .count      (count)
  );

  assign out_ev       = l1_event_t'(fifo_q);
  assign ev_hits_o    = out_ev.hits;
  assign ev_addr_o    = out_ev.addr;
  assign ev_lat_err_o = out_ev.lat_err;
  assign ev_ovf_o     = out_ev.ovf;
endmodule

// File: rtl/l1lb_checker.sv
module l1lb_checker #(
  parameter int AW = 8,
  parameter int BD = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] latency_i,
  input logic          push,
  input logic [AW-1:0] push_addr,
  input logic [CW-1:0] count,
  input logic          ovf,
  input logic          rd_req_i,
  input logic          ev_valid_o
);
  p_ptr_step_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> wr_ptr == AW'($past(wr_ptr) + 1'b1));

  p_push_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (push && $past(!rst)) |-> push_addr == AW'($past(wr_ptr) - $past(latency_i)));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(BD));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ovf)) |-> ovf);

  p_valid_req_r7: assert property (@(posedge clk) disable iff (rst)
    ev_valid_o |-> ($past(rd_req_i) && $past(count) != '0));
endmodule

bind l1_latency_buffer l1lb_checker #(
  .AW(l1lb_pkg::PA_W), .BD(BUF_DEPTH), .CW($clog2(BUF_DEPTH + 1))
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_ptr     (wr_ptr),
  .latency_i  (latency_i),
  .push       (push),
  .push_addr  (push_ev.addr),
  .count      (count),
  .ovf        (ovf),
  .rd_req_i   (rd_req_i),
  .ev_valid_o (ev_valid_o)
);

// File: tb/l1_latency_buffer_tb.sv
module l1_latency_buffer_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] hits_i = '0;
  logic         trig_i = 1'b0;
  logic [7:0]   latency_i = '0;
  logic         rd_req_i = 1'b0;
  logic         ev_valid_o;
  logic [127:0] ev_hits_o;
  logic [7:0]   ev_addr_o;
  logic         ev_lat_err_o;
  logic         ev_ovf_o;

  typedef struct {
    logic [127:0] h;
    logic [7:0]   a;
    logic         le;
    logic         ov;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  int   cyc = 0;
  int   occ = 0;
  bit   ovf_m = 1'b0;
  bit   done = 1'b0;

  l1_latency_buffer u_dut (
    .clk(clk), .rst(rst), .hits_i(hits_i), .trig_i(trig_i), .latency_i(latency_i),
    .rd_req_i(rd_req_i), .ev_valid_o(ev_valid_o), .ev_hits_o(ev_hits_o),
    .ev_addr_o(ev_addr_o), .ev_lat_err_o(ev_lat_err_o), .ev_ovf_o(ev_ovf_o)
  );

  always #2 clk = ~clk;

  function automatic logic [127:0] pat(int n);
    logic [31:0] x = n;
    return {x * 32'h9E3779B1, ~x, x ^ 32'h5A5A1234, x * 32'd7 + 32'd1};
  endfunction

  // cyc holds the index of the next rising edge since reset release
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;
  always @(negedge clk) hits_i = pat(cyc);

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Driver: one trigger pulse, expectation pushed at issue time
  task automatic trig_pulse(int L);
    exp_t e;
    int n;
    n = cyc;
    latency_i = 8'(L);
    trig_i = 1'b1;
    e.le = (L == 0) || (L > n);
    e.a  = 8'(n - L);
    e.h  = pat(n - L);
    e.ov = ovf_m;
    if (occ < 32) begin
      q.push_back(e);
      occ++;
    end else begin
      ovf_m = 1'b1;
    end
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic read_one();
    bit was_empty;
    was_empty = (occ == 0);
    rd_req_i = 1'b1;
    if (occ > 0) occ--;
    @(negedge clk);
    rd_req_i = 1'b0;
    if (was_empty) check(ev_valid_o == 1'b0, "R7 empty read", 128'(ev_valid_o), 128'(0));
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic drain();
    while (occ > 0) read_one();
    idle(3);
  endtask

  // Monitor: compare each produced event against the scoreboard head
  always @(negedge clk) begin
    if (!rst && ev_valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R7 unexpected event", 128'(1), 128'(0));
      end else begin
        exp_t e;
        e = q.pop_front();
        check(ev_addr_o == e.a, "R3/R1 address", 128'(ev_addr_o), 128'(e.a));
        check(ev_lat_err_o == e.le, "R4 latency flag", 128'(ev_lat_err_o), 128'(e.le));
        check(ev_ovf_o == e.ov, "R6 overflow flag", 128'(ev_ovf_o), 128'(e.ov));
        if (!e.le) check(ev_hits_o == e.h, "R2 hits", ev_hits_o, e.h);
      end
    end
  end

  task automatic check_reset_outputs();
    check({ev_valid_o, ev_hits_o, ev_addr_o, ev_lat_err_o, ev_ovf_o} == '0,
          "R8 reset outputs", 128'(ev_valid_o) | ev_hits_o, 128'(0));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    q.delete();
    occ = 0;
    ovf_m = 1'b0;
    idle(3);
    check_reset_outputs();
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    idle(1);
    check_reset_outputs();            // R8 after release
    // R4: look-back beyond written history, and zero look-back
    idle(2);
    trig_pulse(10);
    idle(20);
    trig_pulse(0);
    idle(3);
    drain();
    read_one();                       // R7: read request on empty buffer
    // R2/R9: back-to-back triggers with different look-backs after a full lap
    while (cyc < 300) @(negedge clk);
    trig_pulse(1);
    trig_pulse(37);
    trig_pulse(255);
    trig_pulse(128);
    trig_pulse(3);
    idle(3);
    drain();
    // R1: address wraps below zero around the pointer wrap
    while (cyc % 256 != 5) @(negedge clk);
    trig_pulse(20);
    trig_pulse(6);
    idle(3);
    drain();
    // R5/R6: fill the buffer, then overflow it
    for (int i = 0; i < 34; i++) trig_pulse(50);
    idle(3);
    trig_pulse(7);                    // still full: dropped
    idle(3);
    read_one();
    idle(3);
    trig_pulse(9);                    // accepted with overflow flag set
    idle(3);
    drain();
    check(q.size() == 0, "R5 all events returned", 128'(q.size()), 128'(0));
    // R6: reset clears the sticky overflow
    do_reset();
    idle(12);
    trig_pulse(5);
    idle(3);
    drain();
    check(q.size() == 0, "R6 post-reset event seen", 128'(q.size()), 128'(0));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule